// File: doc/BRIEF.md
# Timestamp Event Capture Unit

This block keeps a free-running 32-bit time counter and turns timing events into typed 64-bit records that software reads from a small event queue. Events come from a software push written over the register bus, from four external hardware push pins, from the counter crossing its half-range point or wrapping to zero, and from Ethernet receive and transmit timestamp strobes that carry a port number, a message type and a sequence ID. Every record holds the counter value at the moment of the event, except the two rollover kinds.

Software drives the block through a simple register bus with write strobe, byte address, write data and combinational read data. The counter runs on the bus clock. It can be loaded with a test value. A pending flag is raised while the queue holds events. A per-flag enable masks this flag onto the interrupt output. A test mode lets software force the pending flag. The queue is 16 entries deep. When several events arrive in one cycle, they enter the queue in a fixed priority order. When the queue is full, further events are dropped and a sticky overflow output is set.

Top module: `tsu_evt_capture`

## Requirements
- R1: While control bit 0 (register 0x00) is clear, the counter is held at 0, the queue is empty, the overflow output is 0, and no event is captured. After this bit is set, the counter starts at 0.
- R2: While enabled, the counter increases by one each clock. Writing 1 to bit 0 of register 0x0C copies the value of register 0x08 into the counter. Reading 0x08 returns the last value written there.
- R3: Writing 1 to bit 0 of register 0x04 queues an event of kind 0x0. Its timestamp is the counter value in the cycle of that write. Register 0x04 reads as 0.
- R4: Control bits 8 to 11 enable hardware pins 0 to 3. A rising edge on an enabled pin queues one event of kind 0x3, with port field equal to pin index plus 1. Its timestamp is the counter value in the edge cycle. A disabled pin, or a pin held high, queues nothing.
- R5: When the counter steps from 0x7FFFFFFF to 0x80000000, an event of kind 0x2 is queued. When it steps from 0xFFFFFFFF to 0, an event of kind 0x1 is queued.
- R6: An Ethernet receive strobe queues kind 0x4 and a transmit strobe queues kind 0x5. Each record carries that strobe's port, message type and sequence ID, and the current counter value.
- R7: Register 0x20 returns the head record's timestamp. Register 0x24 returns the sequence ID in bits 15:0, the message type in 19:16, the kind in 23:20, the port in 28:24, and zeros in 31:29. Both registers read 0 while the queue is empty.
- R8: Writing 1 to bit 0 of register 0x1C discards the head record and exposes the next one. This write has no effect on an empty queue.
- R9: Events arriving in the same cycle are queued in this order: receive, transmit, pins 0 to 3, software push, half rollover, full rollover.
- R10: The queue holds 16 records. An event arriving when no slot is free is dropped, and the overflow output is set. The overflow output stays set until control bit 0 is cleared.
- R11: Register 0x10 bit 0 (raw pending) is 1 whenever the queue is non-empty. Register 0x14 bit 0 is the raw bit ANDed with bit 0 of register 0x18. The interrupt output equals that masked bit.
- R12: With control bit 1 set, writing bit 0 of register 0x10 sets or clears a forced pending value that is ORed into the raw bit. With control bit 1 clear, such writes are ignored and the forced value is not applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the bus and the counter |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| hw_pin_i | input | 4 | Hardware push pins |
| eth_rx_stb_i | input | 1 | Ethernet receive timestamp strobe |
| eth_rx_port_i | input | 5 | Receive port number |
| eth_rx_msg_i | input | 4 | Receive message type |
| eth_rx_seq_i | input | 16 | Receive sequence ID |
| eth_tx_stb_i | input | 1 | Ethernet transmit timestamp strobe |
| eth_tx_port_i | input | 5 | Transmit port number |
| eth_tx_msg_i | input | 4 | Transmit message type |
| eth_tx_seq_i | input | 16 | Transmit sequence ID |
| irq_o | output | 1 | Masked pending interrupt |
| ovf_o | output | 1 | Sticky queue overflow flag |

## Verification
The bench builds the block with its default queue depth of 16. At that depth, seventeen back-to-back software pushes reach the drop and overflow path in a few dozen cycles. The 32-bit counter is used as is. Loading values just below 0x80000000 and 0xFFFFFFFF brings both rollover boundaries within three cycles, and loading a known value turns every expected timestamp into a small cycle count from the load write.

// File: rtl/tsu_pkg.sv
package tsu_pkg;

    localparam int TS_W   = 32;
    localparam int NHW    = 4;
    localparam int NSRC   = NHW + 5;

    // Source slots, lower index queued first in a shared cycle
    localparam int SRC_ETHRX = 0;
    localparam int SRC_ETHTX = 1;
    localparam int SRC_HW0   = 2;
    localparam int SRC_SW    = SRC_HW0 + NHW;
    localparam int SRC_HALF  = SRC_SW + 1;
    localparam int SRC_FULL  = SRC_SW + 2;

    // Register word indices (byte address bits 5:2)
    localparam logic [3:0] RG_CTRL   = 4'h0;
    localparam logic [3:0] RG_PUSH   = 4'h1;
    localparam logic [3:0] RG_LDVAL  = 4'h2;
    localparam logic [3:0] RG_LDGO   = 4'h3;
    localparam logic [3:0] RG_RAW    = 4'h4;
    localparam logic [3:0] RG_MASKED = 4'h5;
    localparam logic [3:0] RG_IE     = 4'h6;
    localparam logic [3:0] RG_POP    = 4'h7;
    localparam logic [3:0] RG_EVLO   = 4'h8;
    localparam logic [3:0] RG_EVHI   = 4'h9;

    localparam int CB_EN    = 0;
    localparam int CB_ITEST = 1;
    localparam int CB_HW0   = 8;

    typedef enum logic [3:0] {
        EV_SWPUSH = 4'h0,
        EV_ROLL   = 4'h1,
        EV_HALF   = 4'h2,
        EV_HWPUSH = 4'h3,
        EV_ETHRX  = 4'h4,
        EV_ETHTX  = 4'h5
    } evt_kind_e;

    typedef struct packed {
        logic [4:0]      port;
        evt_kind_e       kind;
        logic [3:0]      msg;
        logic [15:0]     seq;
        logic [TS_W-1:0] ts;
    } evt_rec_t;

    function automatic logic [31:0] rec_hi_word(evt_rec_t r);
        return {3'b000, r.port, r.kind, r.msg, r.seq};
    endfunction

endpackage

// File: rtl/tsu_timebase.sv
module tsu_timebase #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] cnt,
    output logic         half_ev,
    output logic         full_ev
);

    localparam logic [W-1:0] HALF_LAST = {1'b0, {(W-1){1'b1}}};

    always_ff @(posedge clk) begin
        if (rst || !en)
            cnt <= '0;
        else if (ld)
            cnt <= ld_val;
        else
            cnt <= cnt + 1'b1;
    end

    assign half_ev = en && !ld && (cnt == HALF_LAST);
    assign full_ev = en && !ld && (&cnt);

    p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
        (en && !ld) ##1 en |-> cnt == $past(cnt) + 1'b1);

    p_held_zero_r1: assert property (@(posedge clk) disable iff (rst)
        !en |=> cnt == '0);

    p_half_lands_r5: assert property (@(posedge clk) disable iff (rst)
        half_ev |=> cnt == {1'b1, {(W-1){1'b0}}});

endmodule

// File: rtl/tsu_evt_gather.sv
module tsu_evt_gather
    import tsu_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  en,
    input  logic [TS_W-1:0]       cnt,
    input  logic                  half_ev,
    input  logic                  full_ev,
    input  logic                  sw_push,
    input  logic [NHW-1:0]        hw_pin,
    input  logic [NHW-1:0]        hw_en,
    input  logic                  rx_stb,
    input  logic [4:0]            rx_port,
    input  logic [3:0]            rx_msg,
    input  logic [15:0]           rx_seq,
    input  logic                  tx_stb,
    input  logic [4:0]            tx_port,
    input  logic [3:0]            tx_msg,
    input  logic [15:0]           tx_seq,
    output logic [NSRC-1:0]       req,
    output evt_rec_t [NSRC-1:0]   recs
);

    logic [NHW-1:0]  pin_q;
    logic [TS_W-1:0] cnt_nxt;

    always_ff @(posedge clk) begin
        if (rst)
            pin_q <= '0;
        else
            pin_q <= hw_pin;
    end

    assign cnt_nxt = cnt + 1'b1;

    assign req[SRC_ETHRX]  = en && rx_stb;
    assign recs[SRC_ETHRX] = '{port: rx_port, kind: EV_ETHRX, msg: rx_msg,
                               seq: rx_seq, ts: cnt};
    assign req[SRC_ETHTX]  = en && tx_stb;
    assign recs[SRC_ETHTX] = '{port: tx_port, kind: EV_ETHTX, msg: tx_msg,
                               seq: tx_seq, ts: cnt};

    for (genvar k = 0; k < NHW; k++) begin : g_pin
        assign req[SRC_HW0+k]  = en && hw_en[k] && hw_pin[k] && !pin_q[k];
        assign recs[SRC_HW0+k] = '{port: 5'(k + 1), kind: EV_HWPUSH, msg: 4'h0,
                                   seq: 16'h0, ts: cnt};
    end

    assign req[SRC_SW]    = en && sw_push;
    assign recs[SRC_SW]   = '{port: 5'd0, kind: EV_SWPUSH, msg: 4'h0,
                              seq: 16'h0, ts: cnt};
    assign req[SRC_HALF]  = half_ev;
    assign recs[SRC_HALF] = '{port: 5'd0, kind: EV_HALF, msg: 4'h0,
                              seq: 16'h0, ts: cnt_nxt};
    assign req[SRC_FULL]  = full_ev;
    assign recs[SRC_FULL] = '{port: 5'd0, kind: EV_ROLL, msg: 4'h0,
                              seq: 16'h0, ts: cnt_nxt};

    p_roll_exclusive_r5: assert property (@(posedge clk) disable iff (rst)
        !(half_ev && full_ev));

    p_pin_single_r4: assert property (@(posedge clk) disable iff (rst)
        req[SRC_HW0] |=> !req[SRC_HW0]);

endmodule

// File: rtl/tsu_evt_fifo.sv
module tsu_evt_fifo
    import tsu_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int NW    = NSRC
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clr,
    input  logic [NW-1:0]       req,
    input  evt_rec_t [NW-1:0]   recs,
    input  logic                pop,
    output evt_rec_t            head,
    output logic                nonempty,
    output logic                ovf
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int SW = $clog2(DEPTH + NW + 1);

    evt_rec_t        mem [DEPTH];
    logic [AW-1:0]   rptr, wptr;
    logic [CW-1:0]   level;
    logic [SW-1:0]   off [NW];
    logic [NW-1:0]   take;
    logic [SW-1:0]   n_take;
    logic            drop;
    logic            do_pop;

    always_comb begin
        n_take = '0;
        drop   = 1'b0;
        for (int i = 0; i < NW; i++) begin
            off[i]  = n_take;
            take[i] = 1'b0;
            if (req[i]) begin
                if (SW'(level) + n_take < SW'(DEPTH)) begin
                    take[i] = 1'b1;
                    n_take  = n_take + 1'b1;
                end else begin
                    drop = 1'b1;
                end
            end
        end
    end

    assign do_pop = pop && (level != '0);

    always_ff @(posedge clk) begin
        for (int i = 0; i < NW; i++) begin
            if (take[i] && !clr && !rst)
                mem[wptr + AW'(off[i])] <= recs[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            rptr  <= '0;
            wptr  <= '0;
            level <= '0;
            ovf   <= 1'b0;
        end else begin
            wptr  <= wptr + AW'(n_take);
            rptr  <= rptr + AW'(do_pop);
            level <= CW'(SW'(level) + n_take - SW'(do_pop));
            ovf   <= ovf | drop;
        end
    end

    assign nonempty = (level != '0);
    assign head     = nonempty ? mem[rptr] : '0;

    p_level_bound_r10: assert property (@(posedge clk) disable iff (rst)
        level <= CW'(DEPTH));

    p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        ovf && !clr |=> ovf);

    p_pop_empty_r8: assert property (@(posedge clk) disable iff (rst)
        !nonempty && pop && req == '0 && !clr |=> !nonempty);

    p_pop_step_r8: assert property (@(posedge clk) disable iff (rst)
        nonempty && pop && req == '0 && !clr |=> level == $past(level) - 1'b1);

endmodule

// File: rtl/tsu_evt_capture.sv
module tsu_evt_capture
    import tsu_pkg::*;
#(
    parameter int FIFO_DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_we,
    input  logic [5:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic [3:0]  hw_pin_i,
    input  logic        eth_rx_stb_i,
    input  logic [4:0]  eth_rx_port_i,
    input  logic [3:0]  eth_rx_msg_i,
    input  logic [15:0] eth_rx_seq_i,
    input  logic        eth_tx_stb_i,
    input  logic [4:0]  eth_tx_port_i,
    input  logic [3:0]  eth_tx_msg_i,
    input  logic [15:0] eth_tx_seq_i,
    output logic        irq_o,
    output logic        ovf_o
);

    logic [3:0]      widx;
    logic            en_q, itest_q, ie_q, force_q;
    logic [NHW-1:0]  hw_en_q;
    logic [TS_W-1:0] ldval_q;
    logic            wr_push, wr_ldgo, wr_pop;
    logic [TS_W-1:0] cnt;
    logic            half_ev, full_ev;
    logic [NSRC-1:0] req;
    evt_rec_t [NSRC-1:0] recs;
    evt_rec_t        head;
    logic            nonempty;
    logic            raw_pend, masked_pend;
    logic            unused_bits;

    assign widx    = bus_addr[5:2];
    assign wr_push = bus_we && widx == RG_PUSH && bus_wdata[0];
    assign wr_ldgo = bus_we && widx == RG_LDGO && bus_wdata[0] && en_q;
    assign wr_pop  = bus_we && widx == RG_POP  && bus_wdata[0];
    assign unused_bits = ^bus_addr[1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= 1'b0;
            itest_q <= 1'b0;
            hw_en_q <= '0;
            ldval_q <= '0;
            ie_q    <= 1'b0;
            force_q <= 1'b0;
        end else if (bus_we) begin
            case (widx)
                RG_CTRL: begin
                    en_q    <= bus_wdata[CB_EN];
                    itest_q <= bus_wdata[CB_ITEST];
                    hw_en_q <= bus_wdata[CB_HW0 +: NHW];
                end
                RG_LDVAL: ldval_q <= bus_wdata;
                RG_IE:    ie_q    <= bus_wdata[0];
                RG_RAW:   if (itest_q) force_q <= bus_wdata[0];
                default: ;
            endcase
        end
    end

    tsu_timebase #(.W(TS_W)) u_timebase (
        .clk     (clk),
        .rst     (rst),
        .en      (en_q),
        .ld      (wr_ldgo),
        .ld_val  (ldval_q),
        .cnt     (cnt),
        .half_ev (half_ev),
        .full_ev (full_ev)
    );

    tsu_evt_gather u_gather (
        .clk     (clk),
        .rst     (rst),
        .en      (en_q),
        .cnt     (cnt),
        .half_ev (half_ev),
        .full_ev (full_ev),
        .sw_push (wr_push),
        .hw_pin  (hw_pin_i),
        .hw_en   (hw_en_q),
        .rx_stb  (eth_rx_stb_i),
        .rx_port (eth_rx_port_i),
        .rx_msg  (eth_rx_msg_i),
        .rx_seq  (eth_rx_seq_i),
        .tx_stb  (eth_tx_stb_i),
        .tx_port (eth_tx_port_i),
        .tx_msg  (eth_tx_msg_i),
        .tx_seq  (eth_tx_seq_i),
        .req     (req),
        .recs    (recs)
    );

    tsu_evt_fifo #(.DEPTH(FIFO_DEPTH), .NW(NSRC)) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .clr      (!en_q),
        .req      (req),
        .recs     (recs),
        .pop      (wr_pop),
        .head     (head),
        .nonempty (nonempty),
        .ovf      (ovf_o)
    );

    assign raw_pend    = nonempty || (itest_q && force_q);
    assign masked_pend = raw_pend && ie_q;
    assign irq_o       = masked_pend;

    always_comb begin
        case (widx)
            RG_CTRL:   bus_rdata = {20'h0, hw_en_q, 6'h0, itest_q, en_q};
            RG_LDVAL:  bus_rdata = ldval_q;
            RG_RAW:    bus_rdata = {31'h0, raw_pend};
            RG_MASKED: bus_rdata = {31'h0, masked_pend};
            RG_IE:     bus_rdata = {31'h0, ie_q};
            RG_EVLO:   bus_rdata = head.ts;
            RG_EVHI:   bus_rdata = rec_hi_word(head);
            default:   bus_rdata = 32'h0;
        endcase
    end

    p_irq_source_r11: assert property (@(posedge clk) disable iff (rst)
        irq_o && !itest_q |-> nonempty);

    p_disabled_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !en_q |=> !ovf_o && !nonempty);

endmodule

// File: tb/tsu_evt_capture_tb.sv
module tsu_evt_capture_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  hw_pin = '0;
    logic        rx_stb = 1'b0, tx_stb = 1'b0;
    logic [4:0]  rx_port = '0, tx_port = '0;
    logic [3:0]  rx_msg = '0, tx_msg = '0;
    logic [15:0] rx_seq = '0, tx_seq = '0;
    logic        irq, ovf;

    int n_vec  = 0;
    int n_fail = 0;

    localparam logic [5:0] A_CTRL = 6'h00, A_PUSH = 6'h04, A_LDVAL = 6'h08,
                           A_LDGO = 6'h0C, A_RAW = 6'h10, A_MASK = 6'h14,
                           A_IE = 6'h18, A_POP = 6'h1C, A_EVLO = 6'h20,
                           A_EVHI = 6'h24;

    always #10 clk = ~clk;

    tsu_evt_capture #(.FIFO_DEPTH(16)) dut_i (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hw_pin_i(hw_pin),
        .eth_rx_stb_i(rx_stb), .eth_rx_port_i(rx_port), .eth_rx_msg_i(rx_msg),
        .eth_rx_seq_i(rx_seq), .eth_tx_stb_i(tx_stb), .eth_tx_port_i(tx_port),
        .eth_tx_msg_i(tx_msg), .eth_tx_seq_i(tx_seq), .irq_o(irq), .ovf_o(ovf)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic restart(input logic [31:0] ctrl);
        wr(A_CTRL, 32'h0);
        idle(1);
        wr(A_CTRL, ctrl);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(A_CTRL, d); check("R1 ctrl after reset", d, 32'h0);
        rd(A_EVLO, d); check("R1 event low empty", d, 32'h0);
        rd(A_EVHI, d); check("R7 event high empty", d, 32'h0);
        check("R1 irq after reset", {31'h0, irq}, 32'h0);
        check("R1 ovf after reset", {31'h0, ovf}, 32'h0);
    endtask

    task automatic t_enable();
        logic [31:0] d;
        wr(A_PUSH, 32'h1);
        idle(4);
        rd(A_RAW, d); check("R1 push ignored while disabled", d, 32'h0);
        wr(A_CTRL, 32'h1);
        wr(A_PUSH, 32'h1);
        rd(A_EVLO, d); check("R1 counter starts at zero", d, 32'h0);
        wr(A_POP, 32'h1);
        rd(A_RAW, d); check("R1 only one event queued", d, 32'h0);
    endtask

    task automatic t_load();
        logic [31:0] d;
        restart(32'h1);
        wr(A_LDVAL, 32'h1000_0000);
        rd(A_LDVAL, d); check("R2 load value readback", d, 32'h1000_0000);
        wr(A_LDGO, 32'h1);
        idle(5);
        wr(A_PUSH, 32'h1);
        rd(A_EVLO, d); check("R2 counter steps from load", d, 32'h1000_0005);
        rd(A_LDVAL, d); check("R2 load value not time", d, 32'h1000_0000);
        rd(A_PUSH, d); check("R3 push register reads zero", d, 32'h0);
        rd(A_EVHI, d); check("R3 push kind 0", d, 32'h0);
        wr(A_POP, 32'h1);
    endtask

    task automatic t_hw();
        logic [31:0] d;
        restart(32'h0000_0301);
        wr(A_LDVAL, 32'h0000_0500);
        wr(A_LDGO, 32'h1);
        hw_pin = 4'b0010;
        idle(4);
        rd(A_EVLO, d); check("R4 pin timestamp", d, 32'h0000_0500);
        rd(A_EVHI, d); check("R4 pin kind and port", d, 32'h0230_0000);
        wr(A_POP, 32'h1);
        rd(A_RAW, d); check("R4 held pin one event", d, 32'h0);
        hw_pin = 4'b0110;
        idle(3);
        rd(A_RAW, d); check("R4 disabled pin ignored", d, 32'h0);
        hw_pin = 4'b0000;
        idle(1);
    endtask

    task automatic t_eth();
        logic [31:0] d;
        restart(32'h1);
        wr(A_LDVAL, 32'h0000_0A00);
        wr(A_LDGO, 32'h1);
        rx_stb = 1'b1; rx_port = 5'd3; rx_msg = 4'hB; rx_seq = 16'hBEEF;
        @(negedge clk);
        rx_stb = 1'b0;
        tx_stb = 1'b1; tx_port = 5'h1F; tx_msg = 4'h2; tx_seq = 16'h0102;
        @(negedge clk);
        tx_stb = 1'b0;
        rd(A_EVLO, d); check("R6 receive timestamp", d, 32'h0000_0A00);
        rd(A_EVHI, d); check("R7 receive high word", d, 32'h034B_BEEF);
        wr(A_POP, 32'h1);
        rd(A_EVLO, d); check("R6 transmit timestamp", d, 32'h0000_0A01);
        rd(A_EVHI, d); check("R7 transmit high word", d, 32'h1F52_0102);
        wr(A_POP, 32'h1);
    endtask

    task automatic t_roll();
        logic [31:0] d;
        restart(32'h1);
        wr(A_LDVAL, 32'h7FFF_FFFE);
        wr(A_LDGO, 32'h1);
        idle(3);
        rd(A_EVHI, d); check("R5 half rollover kind", d, 32'h0020_0000);
        wr(A_POP, 32'h1);
        rd(A_RAW, d); check("R5 single half event", d, 32'h0);
        wr(A_LDVAL, 32'hFFFF_FFFE);
        wr(A_LDGO, 32'h1);
        idle(3);
        rd(A_EVHI, d); check("R5 full rollover kind", d, 32'h0010_0000);
        wr(A_POP, 32'h1);
        rd(A_RAW, d); check("R5 single full event", d, 32'h0);
    endtask

    task automatic t_priority();
        logic [31:0] d;
        restart(32'h0000_0F01);
        rx_port = 5'd3; rx_msg = 4'hB; rx_seq = 16'hBEEF;
        tx_port = 5'h1F; tx_msg = 4'h2; tx_seq = 16'h0102;
        rx_stb = 1'b1; tx_stb = 1'b1; hw_pin = 4'hF;
        wr(A_PUSH, 32'h1);
        rx_stb = 1'b0; tx_stb = 1'b0;
        rd(A_EVHI, d); check("R9 first is receive", d, 32'h034B_BEEF);
        wr(A_POP, 32'h1);
        rd(A_EVHI, d); check("R9 second is transmit", d, 32'h1F52_0102);
        wr(A_POP, 32'h1);
        for (int k = 1; k <= 4; k++) begin
            rd(A_EVHI, d);
            check("R9 pin order", d, (32'(k) << 24) | 32'h0030_0000);
            wr(A_POP, 32'h1);
        end
        rd(A_RAW, d); check("R9 software push last", d, 32'h1);
        wr(A_POP, 32'h1);
        rd(A_RAW, d); check("R9 seven events total", d, 32'h0);
        hw_pin = 4'h0;
        idle(1);
    endtask

    task automatic t_pop_empty();
        logic [31:0] d;
        restart(32'h1);
        wr(A_POP, 32'h1);
        wr(A_POP, 32'h1);
        wr(A_PUSH, 32'h1);
        rd(A_RAW, d); check("R8 event after empty pops", d, 32'h1);
        wr(A_POP, 32'h1);
        rd(A_RAW, d); check("R8 empty pop left no debt", d, 32'h0);
        rd(A_EVLO, d); check("R7 low zero when empty", d, 32'h0);
    endtask

    task automatic t_overflow();
        logic [31:0] d;
        restart(32'h1);
        wr(A_LDVAL, 32'h0000_0100);
        wr(A_LDGO, 32'h1);
        for (int i = 0; i < 17; i++) wr(A_PUSH, 32'h1);
        check("R10 overflow set", {31'h0, ovf}, 32'h1);
        for (int i = 0; i < 16; i++) begin
            rd(A_EVLO, d);
            check("R10 queued timestamp", d, 32'h0000_0100 + 32'(i));
            wr(A_POP, 32'h1);
        end
        rd(A_RAW, d); check("R10 seventeenth dropped", d, 32'h0);
        check("R10 overflow sticky", {31'h0, ovf}, 32'h1);
        wr(A_CTRL, 32'h0);
        idle(1);
        check("R10 overflow cleared by disable", {31'h0, ovf}, 32'h0);
    endtask

    task automatic t_irq();
        logic [31:0] d;
        restart(32'h1);
        wr(A_IE, 32'h0);
        wr(A_PUSH, 32'h1);
        rd(A_RAW, d); check("R11 raw set", d, 32'h1);
        rd(A_MASK, d); check("R11 masked off", d, 32'h0);
        check("R11 irq masked", {31'h0, irq}, 32'h0);
        wr(A_IE, 32'h1);
        rd(A_MASK, d); check("R11 masked on", d, 32'h1);
        check("R11 irq raised", {31'h0, irq}, 32'h1);
        wr(A_POP, 32'h1);
        check("R11 irq drops when empty", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_inttest();
        logic [31:0] d;
        restart(32'h1);
        wr(A_IE, 32'h1);
        wr(A_RAW, 32'h1);
        rd(A_RAW, d); check("R12 raw write ignored", d, 32'h0);
        wr(A_CTRL, 32'h3);
        rd(A_RAW, d); check("R12 earlier write not kept", d, 32'h0);
        wr(A_RAW, 32'h1);
        rd(A_RAW, d); check("R12 forced raw", d, 32'h1);
        check("R12 forced irq", {31'h0, irq}, 32'h1);
        wr(A_RAW, 32'h0);
        rd(A_RAW, d); check("R12 forced clear", d, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_enable();
        t_load();
        t_hw();
        t_eth();
        t_roll();
        t_priority();
        t_pop_empty();
        t_overflow();
        t_irq();
        t_inttest();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        #(20 * 100000);
        n_vec++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule